// File: doc/BRIEF.md
# Flux Bit-Cell Recovery Counter

This block turns a raw stream of flux-transition pulses from a magnetic read channel into serial data bits. It runs on a fixed sample clock and uses no PLL. A cycle counter with a loadable preset sets the length of one bit cell, and a 4-bit cell counter counts whole cells since the last transition. Each flux transition restarts both counters. Each bit value is decoded from the cell counter at a fixed point inside the cell.

The preset picks the density zone. A cell lasts `16 - preset` sample cycles. The preset is latched only while the block is idle, so the cell length stays fixed while a track is being read. Besides the recovered bit and its one-cycle valid strobe, the block gives a mid-cell strobe that a write serializer uses as its shift clock.

Top module: `flux_cell_recovery`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `bit_o`, `bit_vld_o` and `mid_o` are 0. Both counters clear to 0, so no strobe can appear within the first 16 cycles after reset.
- R2: `flux_i` passes through two synchronizer flops before a rising-edge detect. Only a 0-to-1 change counts as a transition, and it counts once. A level held high, and a falling edge, have no effect.
- R3: A detected transition loads the cycle counter with the latched preset and clears the cell counter to 0. This takes priority over a terminal count in the same cycle.
- R4: Without a transition, the cycle counter adds one each cycle. When it would pass 15 it reloads the preset instead and the cell counter advances by one, modulo 16. One cell therefore lasts `16 - preset` cycles.
- R5: `bit_vld_o` is a one-cycle pulse. It goes high in the cycle after the cell counter's bit 1 changes from 0 to 1, that is, when it becomes 2, 6, 10 or 14.
- R6: When `bit_vld_o` is high, `bit_o` equals the NOR of bits 3 and 2 of the new cell count. It is 1 at count 2 and 0 at 6, 10 and 14. Between strobes `bit_o` holds its value.
- R7: `mid_o` is a one-cycle pulse in the cycle after cell-counter bit 1 changes from 1 to 0 (count becomes 4, 8 or 12, or 0 by wrap or by a transition).
- R8: The preset is sampled from `preset_i` only while idle. Idle holds from reset until the first transition, and again once the cell counter wraps from 15 to 0 with no transition. While active, changes on `preset_i` do not alter the cell length.
- R9: Preset 15 gives one-cycle cells, and preset 0 gives 16-cycle cells. In both cases the first bit strobe comes 2 + 2·(16 − preset) cycles after the synchronized transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flux_i | input | 1 | Raw flux-transition pulse, asynchronous |
| preset_i | input | 4 | Density preset for the cycle counter |
| bit_o | output | 1 | Recovered data bit |
| bit_vld_o | output | 1 | One-cycle strobe, `bit_o` is new |
| mid_o | output | 1 | One-cycle mid-cell strobe for the write path |

## Verification
A flux transition can arrive in the same cycle that the cycle counter hits its terminal count. The reload then has to win over the cell increment. Preset 15 provokes this on every transition, because the counter sits at its terminal value every cycle. If the increment won instead, the first bit strobe would come one cell early, so its exact position settles the question. A second transition that lands at an arbitrary point inside a running cell is judged the same way, by where the strobe falls after it.

// File: rtl/flux_rec_pkg.sv
package flux_rec_pkg;
  localparam int DEF_CNT_W   = 4;
  localparam int DEF_CELL_W  = 4;
  localparam int DEF_SYNC_N  = 2;
endpackage

// File: rtl/flux_sync.sv
module flux_sync #(
  parameter int STAGES = flux_rec_pkg::DEF_SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flux_i,
  output logic edge_o
);
  // [STAGES-1:0] synchronizer, [STAGES] previous synchronized level
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], flux_i};
  end

  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R2
  single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/cell_timer.sv
module cell_timer #(
  parameter int CNT_W  = flux_rec_pkg::DEF_CNT_W,
  parameter int CELL_W = flux_rec_pkg::DEF_CELL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic [CNT_W-1:0]  preset_i,
  output logic              samp_q_o,
  output logic [CELL_W-1:1] cell_nx_o
);
  localparam int SAMP = CELL_W - 3;

  logic [CNT_W-1:0]  cyc_q, cyc_d, preset_q;
  logic [CELL_W-1:0] cell_q, cell_d;
  logic              active_q, active_d, term, wrap;

  assign term = &cyc_q;

  always_comb begin
    cyc_d  = cyc_q + 1'b1;
    cell_d = cell_q;
    wrap   = 1'b0;
    if (edge_i) begin
      cyc_d  = preset_q;
      cell_d = '0;
    end else if (term) begin
      cyc_d  = preset_q;
      cell_d = cell_q + 1'b1;
      wrap   = &cell_q;
    end
  end

  always_comb begin
    active_d = active_q;
    if (edge_i)    active_d = 1'b1;
    else if (wrap) active_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q    <= '0;
      cell_q   <= '0;
      active_q <= 1'b0;
      preset_q <= '0;
    end else begin
      cyc_q    <= cyc_d;
      cell_q   <= cell_d;
      active_q <= active_d;
      if (!active_q) preset_q <= preset_i;
    end
  end

  assign samp_q_o  = cell_q[SAMP];
  assign cell_nx_o = cell_d[CELL_W-1:1];

  // R3
  edge_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> (cell_q == '0) && (cyc_q == $past(preset_q)));
  // R4
  cell_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i && term) |=> cell_q == CELL_W'($past(cell_q) + 1'b1));
  // R4
  cell_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i && !term) |=> $stable(cell_q) && (cyc_q == CNT_W'($past(cyc_q) + 1'b1)));
  // R8
  preset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> $stable(preset_q));
endmodule

// File: rtl/bit_slicer.sv
module bit_slicer #(
  parameter int CELL_W = flux_rec_pkg::DEF_CELL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_q_i,
  input  logic [CELL_W-1:1] cell_nx_i,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic              mid_o
);
  localparam int SAMP = CELL_W - 3;

  logic rise, fall;
  assign rise = ~samp_q_i & cell_nx_i[SAMP];
  assign fall = samp_q_i & ~cell_nx_i[SAMP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      mid_o     <= 1'b0;
    end else begin
      bit_vld_o <= rise;
      mid_o     <= fall;
      if (rise) bit_o <= ~|cell_nx_i[CELL_W-1:CELL_W-2];
    end
  end

  // R6
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_o |-> $stable(bit_o));
  // R5
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);
  // R7
  mid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_o |-> !bit_vld_o);
endmodule

// File: rtl/flux_cell_recovery.sv
module flux_cell_recovery #(
  parameter int CNT_W  = flux_rec_pkg::DEF_CNT_W,
  parameter int CELL_W = flux_rec_pkg::DEF_CELL_W,
  parameter int SYNC_N = flux_rec_pkg::DEF_SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flux_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             mid_o
);
  logic              flux_edge;
  logic              samp_q;
  logic [CELL_W-1:1] cell_nx;

  flux_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .flux_i(flux_i),
    .edge_o(flux_edge)
  );

  cell_timer #(.CNT_W(CNT_W), .CELL_W(CELL_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (flux_edge),
    .preset_i (preset_i),
    .samp_q_o (samp_q),
    .cell_nx_o(cell_nx)
  );

  bit_slicer #(.CELL_W(CELL_W)) u_slicer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .samp_q_i (samp_q),
    .cell_nx_i(cell_nx),
    .bit_o    (bit_o),
    .bit_vld_o(bit_vld_o),
    .mid_o    (mid_o)
  );
endmodule

// File: tb/flux_cell_recovery_tb.sv
module flux_cell_recovery_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flux = 1'b0;
  logic [3:0] preset = 4'd0;
  logic       bit_o, bit_vld, mid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flux_cell_recovery u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .flux_i   (flux),
    .preset_i (preset),
    .bit_o    (bit_o),
    .bit_vld_o(bit_vld),
    .mid_o    (mid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Raise flux, hold it for 'hold' samples, record strobe positions.
  // Sample n is taken at the negedge after the (n-1)th posedge past the first one seeing flux high.
  task automatic pulse_measure(input int hold, input int chg_at, input logic [3:0] chg_val,
                               output int v1, output int b1, output int m1, output int bm,
                               output int v2, output int b2, output int vw);
    v1 = 0; b1 = -1; m1 = 0; bm = -1; v2 = 0; b2 = -1; vw = -1;
    @(negedge clk) flux = 1'b1;
    for (int n = 1; n <= 130; n++) begin
      @(negedge clk);
      if (n == hold) flux = 1'b0;
      if (n == chg_at) preset = chg_val;
      if (n > 3) begin
        if (v1 != 0 && n == v1 + 1) vw = bit_vld;
        if (bit_vld && v1 == 0) begin v1 = n; b1 = bit_o; end
        else if (bit_vld && v1 != 0 && v2 == 0) begin v2 = n; b2 = bit_o; end
        if (mid && v1 != 0 && m1 == 0) begin m1 = n; bm = bit_o; end
      end
      if (v2 != 0 && n > v2 + 1) break;
    end
    flux = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (280) @(negedge clk);
  endtask

  task automatic t_reset();
    int seen = 0;
    chk(bit_o == 1'b0, "R1 bit_o", bit_o, 0);
    chk(bit_vld == 1'b0 && mid == 1'b0, "R1 strobes", {bit_vld, mid}, 0);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (bit_vld || mid) seen++;
    end
    chk(seen == 0, "R1 quiet after reset", seen, 0);
  endtask

  task automatic t_cell(input logic [3:0] p, input string req);
    int v1, b1, m1, bm, v2, b2, vw, len;
    len = 16 - int'(p);
    wait_idle();
    preset = p;
    repeat (3) @(negedge clk);
    pulse_measure(1, 0, 4'd0, v1, b1, m1, bm, v2, b2, vw);
    chk(v1 == 3 + 2*len, {req, " R3 R5 first strobe"}, v1, 3 + 2*len);
    chk(b1 == 1, {req, " R6 bit at count 2"}, b1, 1);
    chk(vw == 0, {req, " R5 one-cycle strobe"}, vw, 0);
    chk(m1 == 3 + 4*len, {req, " R7 mid strobe"}, m1, 3 + 4*len);
    chk(bm == 1, {req, " R6 bit held"}, bm, 1);
    chk(v2 == 3 + 6*len, {req, " R4 second strobe"}, v2, 3 + 6*len);
    chk(b2 == 0, {req, " R6 bit at count 6"}, b2, 0);
  endtask

  task automatic t_preset_lock();
    int v1, b1, m1, bm, v2, b2, vw;
    wait_idle();
    preset = 4'd12;
    repeat (3) @(negedge clk);
    pulse_measure(1, 4, 4'd8, v1, b1, m1, bm, v2, b2, vw);
    chk(v1 == 11, "R8 change while active ignored", v1, 11);
    pulse_measure(1, 0, 4'd0, v1, b1, m1, bm, v2, b2, vw);
    chk(v1 == 11, "R8 still locked on retrigger", v1, 11);
    chk(v2 == 27, "R8 locked cell length", v2, 27);
    wait_idle();
    pulse_measure(1, 0, 4'd0, v1, b1, m1, bm, v2, b2, vw);
    chk(v1 == 19, "R8 new preset after idle", v1, 19);
  endtask

  task automatic t_level();
    int v1, b1, m1, bm, v2, b2, vw;
    wait_idle();
    preset = 4'd12;
    repeat (3) @(negedge clk);
    pulse_measure(20, 0, 4'd0, v1, b1, m1, bm, v2, b2, vw);
    chk(v1 == 11, "R2 held level first strobe", v1, 11);
    chk(m1 == 19, "R2 held level mid", m1, 19);
    chk(v2 == 27, "R2 falling edge ignored", v2, 27);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(bit_o == 1'b0 && bit_vld == 1'b0 && mid == 1'b0, "R1 in reset", {bit_o, bit_vld, mid}, 0);
    rst_n = 1'b1;
    t_reset();
    t_cell(4'd12, "P12");
    t_cell(4'd15, "R9 P15");
    t_cell(4'd0,  "R9 P0");
    t_cell(4'd8,  "P8");
    t_preset_lock();
    t_level();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule